// File: doc/BRIEF.md
# Serial Unique-Identifier Capture

This block fetches a fixed 64-bit device identifier from a serial, non-volatile identifier store and turns it into a parallel word with a valid flag. After a synchronous reset it starts a single read on its own. It pulses a load strobe so that the store latches its contents, waits one cycle for the store to settle, and then clocks the 64 identifier bits in, most significant bit first. One cycle after the last bit it raises the valid flag.

Once the flag is high the block stops. It drives no further control to the store and ignores the serial line. The captured word stays frozen until the next reset, which clears the flag and starts a fresh read. While the flag is low the word output reads zero, so consumers qualify it with the flag. The whole read takes 67 cycles, counted from the load cycle up to the edge that sets the flag.

The sequencer states are `ST_IDLE`, `ST_LOAD`, `ST_SETTLE`, `ST_SHIFT`, `ST_FINISH` and `ST_HOLD`. Their transitions are:
- IDLE→LOAD: unconditional, on the first clock after reset.
- LOAD→SETTLE: unconditional.
- SETTLE→SHIFT: unconditional.
- SHIFT→SHIFT: while the bit counter is below 63.
- SHIFT→FINISH: when the bit counter reaches 63.
- FINISH→HOLD: unconditional.
- HOLD→HOLD: held until reset.
- Any state→IDLE: on reset.

Top module: `uid_capture`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge `id_valid`=0, `id_word`=0, `src_load`=0 and `src_shift`=0.
- R2: On the first clock edge after `rst` falls, `src_load` goes high, and it stays high for exactly one cycle.
- R3: In the cycle after the load cycle (the settle cycle), `src_load` and `src_shift` are both low.
- R4: After the settle cycle, `src_shift` is high for exactly 64 consecutive cycles. On each of those cycles the block samples `src_bit` at the clock edge that ends the cycle. The first sampled bit becomes `id_word[63]` and the last becomes `id_word[0]`.
- R5: `id_valid` rises at the 67th clock edge counted from the start of the load cycle, and not before. With edge 1 being the first edge after reset release, this is edge 68.
- R6: While `id_valid` is low, `id_word` reads all zeros.
- R7: While `id_valid` is high, `id_word` holds the captured value and does not change, and `src_load` and `src_shift` stay low. Activity on `src_bit` has no effect.
- R8: A reset, whether in the middle of a read or after the flag has been set, clears `id_valid` and starts a new complete read. The new read captures the value the store presents at that time.
- R9: If reset is high at the edge that would set `id_valid`, reset wins. `id_valid` stays low and the sequence restarts from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_bit | input | 1 | Serial data bit from the identifier store |
| src_load | output | 1 | One-cycle strobe that makes the store latch its identifier and present its MSB |
| src_shift | output | 1 | High while the store should advance one bit per clock |
| id_word | output | 64 | Captured identifier, zero while not valid |
| id_valid | output | 1 | High once the full identifier has been captured |

## Verification
Two functions can fall in the same cycle. One is the final step of a read, the edge that moves FINISH to HOLD and would set `id_valid`. The other is a synchronous reset. The bench runs a read to the FINISH cycle and raises `rst` just before that edge. It then expects the flag and word to stay at zero and a clean full read to follow. A second collision, a reset in the middle of the shift phase, is judged the same way: the read must restart and capture a new pattern.

// File: rtl/uid_pkg.sv
package uid_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETTLE,
        ST_SHIFT,
        ST_FINISH,
        ST_HOLD
    } uid_state_t;
endpackage

// File: rtl/uid_seq.sv
module uid_seq
    import uid_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic clk,
    input  logic rst,
    output logic load_o,
    output logic shift_o,
    output logic valid_o
);
    localparam int CW = $clog2(ID_W);
    localparam logic [CW-1:0] LAST = CW'(ID_W - 1);

    uid_state_t state, state_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_SHIFT;
            ST_SHIFT:  state_nx = (cnt == LAST) ? ST_FINISH : ST_SHIFT;
            ST_FINISH: state_nx = ST_HOLD;
            ST_HOLD:   state_nx = ST_HOLD;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state == ST_SHIFT) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        load_o  = 1'b0;
        shift_o = 1'b0;
        valid_o = 1'b0;
        unique case (state)
            ST_LOAD:  load_o  = 1'b1;
            ST_SHIFT: shift_o = 1'b1;
            ST_HOLD:  valid_o = 1'b1;
            default: ;
        endcase
    end

    // R2: the load strobe lasts one cycle
    a_r2_load_single: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);
    // R3: the settle cycle is quiet
    a_r3_settle_quiet: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !shift_o);
    // R4: the shift run ends only after the last bit
    a_r4_shift_len: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_o) |-> $past(cnt) == LAST);
    // R5: the flag follows the end of the shift run
    a_r5_valid_after_shift: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_o) |=> valid_o);
endmodule

// File: rtl/uid_shreg.sv
module uid_shreg #(
    parameter int ID_W = 64,
    parameter bit ZERO_WHEN_INVALID = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            din,
    input  logic            valid,
    output logic [ID_W-1:0] word_o
);
    logic [ID_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (en)
            sreg <= {sreg[ID_W-2:0], din};
    end

    generate
        if (ZERO_WHEN_INVALID) begin : g_mask
            assign word_o = valid ? sreg : '0;
        end else begin : g_pass
            assign word_o = sreg;
        end
    endgenerate

    // R7: register frozen while not shifting
    a_r7_reg_frozen: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sreg));
endmodule

// File: rtl/uid_capture.sv
module uid_capture #(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            src_bit,
    output logic            src_load,
    output logic            src_shift,
    output logic [ID_W-1:0] id_word,
    output logic            id_valid
);
    uid_seq #(.ID_W(ID_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load_o  (src_load),
        .shift_o (src_shift),
        .valid_o (id_valid)
    );

    uid_shreg #(.ID_W(ID_W), .ZERO_WHEN_INVALID(1'b1)) u_shreg (
        .clk    (clk),
        .rst    (rst),
        .en     (src_shift),
        .din    (src_bit),
        .valid  (id_valid),
        .word_o (id_word)
    );

    // R7: no store traffic while valid
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> (!src_load && !src_shift));
    // R7: word frozen while valid
    a_r7_word_stable: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> $stable(id_word));
    // R7: valid stays until reset
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> id_valid);
endmodule

// File: tb/uid_capture_test.sv
module uid_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_bit;
    logic        src_load, src_shift, id_valid;
    logic [63:0] id_word;

    logic [63:0] src_id = '0;
    logic [6:0]  ptr = '0;
    logic [5:0]  idx;
    logic        noise_en = 1'b0;
    logic        noise_bit = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // behavioural identifier store
    always_ff @(posedge clk) begin
        if (src_load) ptr <= '0;
        else if (src_shift && ptr < 7'd64) ptr <= ptr + 7'd1;
    end
    assign idx = 6'd63 - ptr[5:0];
    assign src_bit = noise_en ? noise_bit : ((ptr < 7'd64) ? src_id[idx] : 1'b0);

    uid_capture uut (
        .clk       (clk),
        .rst       (rst),
        .src_bit   (src_bit),
        .src_load  (src_load),
        .src_shift (src_shift),
        .id_word   (id_word),
        .id_valid  (id_valid)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        check(id_valid == 1'b0, "R1 valid", 64'(id_valid), 64'd0);
        check(id_word == '0, "R1 word", id_word, 64'd0);
        check(!src_load && !src_shift, "R1 ctrl", {62'd0, src_load, src_shift}, 64'd0);
        rst = 1'b0;
    endtask

    // reset then run to the FINISH cycle (after edge 67)
    task automatic run_to_finish(input logic [63:0] pat);
        bit bad;
        src_id = pat;
        do_reset();
        tick();
        check(src_load == 1'b1 && !src_shift, "R2 load", 64'(src_load), 64'd1);
        tick();
        check(!src_load && !src_shift, "R3 settle", {62'd0, src_load, src_shift}, 64'd0);
        bad = 1'b0;
        for (int i = 0; i < 64; i++) begin
            tick();
            if (!src_shift || src_load || id_valid || id_word != '0) bad = 1'b1;
        end
        check(!bad, "R4/R6 shift phase", 64'(bad), 64'd0);
        tick();
        check(!src_shift, "R4 shift count", 64'(src_shift), 64'd0);
        check(!id_valid, "R5 not early", 64'(id_valid), 64'd0);
        check(id_word == '0, "R6 zero", id_word, 64'd0);
    endtask

    task automatic t_acquire(input logic [63:0] pat);
        run_to_finish(pat);
        tick();
        check(id_valid == 1'b1, "R5 valid at edge 68", 64'(id_valid), 64'd1);
        check(id_word == pat, "R4 value", id_word, pat);
    endtask

    task automatic t_hold(input logic [63:0] pat);
        bit bad;
        t_acquire(pat);
        src_id = ~pat;
        noise_en = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            noise_bit = ~noise_bit;
            tick();
            if (!id_valid || id_word != pat || src_load || src_shift) bad = 1'b1;
        end
        noise_en = 1'b0;
        check(!bad, "R7 hold", id_word, pat);
    endtask

    task automatic t_reset_midway(input logic [63:0] a, input logic [63:0] b);
        src_id = a;
        do_reset();
        for (int i = 0; i < 32; i++) tick();
        rst = 1'b1;
        tick();
        check(!id_valid && id_word == '0, "R8 midway clear", id_word, 64'd0);
        t_acquire(b);
    endtask

    task automatic t_reset_after_valid(input logic [63:0] a, input logic [63:0] b);
        t_acquire(a);
        rst = 1'b1;
        tick();
        check(!id_valid, "R8 clear valid", 64'(id_valid), 64'd0);
        t_acquire(b);
        check(id_word == b, "R8 new value", id_word, b);
    endtask

    task automatic t_reset_at_finish(input logic [63:0] pat);
        run_to_finish(pat);
        rst = 1'b1;
        tick();
        check(!id_valid, "R9 reset wins", 64'(id_valid), 64'd0);
        check(id_word == '0, "R9 word zero", id_word, 64'd0);
        rst = 1'b0;
        tick();
        check(src_load == 1'b1, "R9 restart load", 64'(src_load), 64'd1);
        t_acquire(pat);
    endtask

    initial begin
        @(negedge clk);
        t_acquire(64'hA5C3_0F1E_9B72_4D68);
        t_acquire(64'hFFFF_FFFF_FFFF_FFFF);
        t_acquire(64'h0000_0000_0000_0000);
        t_acquire(64'h8000_0000_0000_0001);
        t_hold(64'h1234_5678_9ABC_DEF0);
        t_reset_midway(64'hDEAD_BEEF_0000_1111, 64'h0F0F_F0F0_3C3C_C3C3);
        t_reset_after_valid(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        t_reset_at_finish(64'h5555_AAAA_3333_CCCC);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule